// File: doc/BRIEF.md
# SDRAM Burst Data-Path Timer

This block times the data side of one SDRAM burst. A mode-register write sets the burst length, the beat order, the CAS latency and whether writes are single-word. After that, each decoded READ or WRITE command, with an optional auto-precharge flag, starts a burst. The block then produces, cycle by cycle, a read-data-valid strobe, a DQ output-enable window, a write-data strobe, per-byte enables derived from the byte mask inputs, the column index of the beat in progress, and a one-cycle pulse marking when the internal auto-precharge begins.

The caller decodes commands and drives the pins. It uses `dq_oe` to turn the data bus around, and `rd_valid`, `wr_strobe` and the byte enables to move data to and from its own buffers. Commands, masks and the mode word are sampled on the rising clock edge. The outputs are plain per-cycle strobes with no handshake, because the burst timing is fixed and the bus has no back-pressure: a beat not taken in its cycle is lost. A mode load that arrives with a command only applies from the next cycle.

Top module: `sdram_burst_timer`

## Requirements
- R1: Mode word fields are: burst-length code in bits 2:0 (0,1,2,3 give 1,2,4,8 beats), beat order in bit 3 (0 sequential, 1 interleaved), CAS latency in bits 6:4 (2 or 3), a reserved bit 7 that must be 0, and write mode in bits 9:8 (00 burst writes, 10 single writes). A load takes effect in the next cycle. After reset the mode is 1 beat, latency 2, sequential, burst writes, and every output is low.
- R2: A mode word with any unsupported field (length code 4 to 7, latency other than 2 or 3, bit 7 set, write mode 01 or 11) installs 1 beat, latency 2, sequential order and burst writes, and sets `mode_err`. `mode_err` stays set until reset, even through later valid loads.
- R3: For a READ in cycle c, `rd_valid` is high in cycles c+CL through c+CL+BL-1, and `col_out` gives each beat's column in those cycles.
- R4: `dq_oe` rises in cycle c+CL-1, stays high through the last read beat, and is low in the cycle after it unless another read keeps it up.
- R5: For a WRITE in cycle c, `wr_strobe` is high from cycle c itself for BL cycles, with `col_out` giving each beat's column. In single-write mode only cycle c is strobed, whatever BL is.
- R6: Beat k of a burst that starts at column s uses column s XOR k in interleaved order. In sequential order the low log2(BL) bits count up from s and wrap inside the BL-aligned block, and the upper bits stay unchanged.
- R7: During a read beat, `rd_byte_en[i]` is the inverse of `dqm_in[i]` as sampled two cycles earlier. During a write beat, `wr_byte_en[i]` is the inverse of `dqm_in[i]` in the same cycle. Both are all-zero outside their strobes.
- R8: With the auto-precharge flag, `pre_start` pulses for one cycle in cycle c+BL for a read. That is two cycles before the last data at latency 3 and one cycle before it at latency 2. For a write, the pulse comes in the cycle after the last written beat. A burst cut short by a later command never pulses.
- R9: A READ during a read burst lets the earlier data keep flowing until the new data starts CL cycles later, with no gap and no overlap.
- R10: A WRITE during a read burst drops `rd_valid` and `dq_oe` from the write's own cycle onward and cancels every read beat still in flight.
- R11: A READ during a write burst ends the write, so the last write strobe is in the cycle before the READ.
- R12: When READ and WRITE are both asserted in one cycle, the READ is taken and the WRITE is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load `mode_word` into the mode register |
| mode_word | input | 10 | Mode register fields (see R1) |
| cmd_rd | input | 1 | Decoded READ command |
| cmd_wr | input | 1 | Decoded WRITE command |
| cmd_ap | input | 1 | Auto-precharge flag for the command |
| cmd_col | input | COL_W | Start column of the burst |
| dqm_in | input | NBYTE | Byte mask inputs, high masks the byte |
| rd_valid | output | 1 | Read data beat present this cycle |
| dq_oe | output | 1 | Data bus output-enable window |
| rd_byte_en | output | NBYTE | Unmasked bytes of the current read beat |
| wr_strobe | output | 1 | Write data beat taken this cycle |
| wr_byte_en | output | NBYTE | Bytes written in the current write beat |
| col_out | output | COL_W | Column of the current read or write beat |
| pre_start | output | 1 | Internal auto-precharge begins this cycle |
| mode_err | output | 1 | Sticky flag for an unsupported mode word |

## Verification
The bench builds the block with its defaults: 10-bit columns and four byte lanes. With 10 bits, start columns can sit near an aligned-block edge, so sequential wrap and XOR ordering are both visible at burst lengths 2, 4 and 8. Four lanes let a rotating mask pattern show the two-cycle read mask latency apart from the same-cycle write mask. Both CAS latencies are loaded at run time, so the auto-precharge alignment and each kind of interrupted burst are seen under each latency and each write mode.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  localparam int MODE_W      = 10;
  localparam int MAX_CL      = 3;
  localparam int RD_MASK_LAT = 2;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_INTL = 1'b1} order_e;

  typedef struct packed {
    logic [3:0] blen;      // beats per burst: 1, 2, 4 or 8
    logic [1:0] cl;        // CAS latency: 2 or 3
    order_e     order;
    logic       single_wr;
  } mode_t;

  localparam mode_t MODE_SAFE = '{blen: 4'd1, cl: 2'd2, order: ORD_SEQ, single_wr: 1'b0};

  // Returns the decoded mode; ok reports whether every field was supported.
  function automatic mode_t decode_mode(input logic [MODE_W-1:0] w, output logic ok);
    mode_t m;
    logic [2:0] len_code, lat_code;
    logic [1:0] wmode;
    len_code = w[2:0];
    lat_code = w[6:4];
    wmode    = w[9:8];
    ok = (len_code < 3'd4) && (lat_code == 3'd2 || lat_code == 3'd3) &&
         !w[7] && (wmode == 2'b00 || wmode == 2'b10);
    if (ok) begin
      m.blen      = 4'd1 << len_code;
      m.cl        = lat_code[1:0];
      m.order     = order_e'(w[3]);
      m.single_wr = wmode[1];
    end else begin
      m = MODE_SAFE;
    end
    return m;
  endfunction

endpackage

// File: rtl/sdr_dp_mode.sv
module sdr_dp_mode
  import sdr_dp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode,
  output logic              err
);
  mode_t dec;
  logic  dec_ok;

  always_comb dec = decode_mode(word, dec_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_SAFE;
      err  <= 1'b0;
    end else if (load) begin
      mode <= dec;
      if (!dec_ok) err <= 1'b1;
    end
  end
endmodule

// File: rtl/sdr_dp_beats.sv
module sdr_dp_beats
  import sdr_dp_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_ap,
  input  logic [COL_W-1:0] cmd_col,
  input  mode_t            mode,
  output logic             beat_v,
  output logic             beat_rd,
  output logic [COL_W-1:0] beat_col,
  output logic             pre_start
);
  logic             act_q, rd_q, ap_q, pre_q;
  order_e           ord_q;
  logic [3:0]       idx_q, len_q;
  logic [COL_W-1:0] base_q;

  logic             go, ap_cur, last;
  logic [3:0]       len_cmd, len_cur, k;
  logic [COL_W-1:0] st;
  order_e           ord;

  function automatic logic [COL_W-1:0] beat_addr(input logic [COL_W-1:0] s,
                                                 input logic [3:0] kk,
                                                 input logic [3:0] n,
                                                 input order_e o);
    logic [COL_W-1:0] m, kx;
    m  = COL_W'(n) - COL_W'(1);
    kx = COL_W'(kk);
    if (o == ORD_INTL) return s ^ kx;
    return (s & ~m) | ((s + kx) & m);
  endfunction

  always_comb begin
    go      = cmd_rd | cmd_wr;
    len_cmd = (!cmd_rd && mode.single_wr) ? 4'd1 : mode.blen;
    if (go) begin
      beat_v  = 1'b1;
      beat_rd = cmd_rd;
      k       = 4'd0;
      st      = cmd_col;
      ord     = mode.order;
      len_cur = len_cmd;
      ap_cur  = cmd_ap;
    end else begin
      beat_v  = act_q;
      beat_rd = rd_q;
      k       = idx_q;
      st      = base_q;
      ord     = ord_q;
      len_cur = len_q;
      ap_cur  = ap_q;
    end
    beat_col = beat_addr(st, k, len_cur, ord);
    last     = ({1'b0, k} + 5'd1) == {1'b0, len_cur};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      ap_q   <= 1'b0;
      pre_q  <= 1'b0;
      ord_q  <= ORD_SEQ;
      idx_q  <= '0;
      len_q  <= 4'd1;
      base_q <= '0;
    end else begin
      pre_q <= beat_v & last & ap_cur;
      if (go) begin
        act_q  <= (len_cmd != 4'd1);
        idx_q  <= 4'd1;
        len_q  <= len_cmd;
        base_q <= cmd_col;
        rd_q   <= cmd_rd;
        ap_q   <= cmd_ap;
        ord_q  <= mode.order;
      end else if (act_q) begin
        idx_q <= idx_q + 4'd1;
        act_q <= ({1'b0, idx_q} + 5'd1) < {1'b0, len_q};
      end
    end
  end

  assign pre_start = pre_q;
endmodule

// File: rtl/sdr_dp_rdpipe.sv
module sdr_dp_rdpipe
  import sdr_dp_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [COL_W-1:0] in_col,
  input  logic             flush,
  input  logic [1:0]       cl,
  output logic             out_v,
  output logic [COL_W-1:0] out_col,
  output logic             oe
);
  logic [MAX_CL:1]  sv;
  logic [COL_W-1:0] sc [1:MAX_CL];
  logic             tap_v, pre_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv <= '0;
      for (int i = 1; i <= MAX_CL; i++) sc[i] <= '0;
    end else begin
      sv[1] <= in_v & ~flush;
      sc[1] <= in_col;
      for (int i = 2; i <= MAX_CL; i++) begin
        sv[i] <= sv[i-1] & ~flush;
        sc[i] <= sc[i-1];
      end
    end
  end

  always_comb begin
    case (cl)
      2'd3:    begin tap_v = sv[3]; pre_v = sv[2]; out_col = sc[3]; end
      default: begin tap_v = sv[2]; pre_v = sv[1]; out_col = sc[2]; end
    endcase
    out_v = tap_v & ~flush;
    oe    = (tap_v | pre_v) & ~flush;
  end
endmodule

// File: rtl/sdram_burst_timer.sv
module sdram_burst_timer
  import sdr_dp_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int NBYTE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_ap,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [NBYTE-1:0]  dqm_in,
  output logic              rd_valid,
  output logic              dq_oe,
  output logic [NBYTE-1:0]  rd_byte_en,
  output logic              wr_strobe,
  output logic [NBYTE-1:0]  wr_byte_en,
  output logic [COL_W-1:0]  col_out,
  output logic              pre_start,
  output logic              mode_err
);
  mode_t            mode;
  logic             beat_v, beat_rd, wr_only;
  logic [COL_W-1:0] beat_col, rd_col;
  logic [NBYTE-1:0] mdl [RD_MASK_LAT];

  sdr_dp_mode u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word),
    .mode(mode), .err(mode_err)
  );

  sdr_dp_beats #(.COL_W(COL_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_ap(cmd_ap),
    .cmd_col(cmd_col), .mode(mode), .beat_v(beat_v), .beat_rd(beat_rd),
    .beat_col(beat_col), .pre_start(pre_start)
  );

  assign wr_only = cmd_wr & ~cmd_rd;

  sdr_dp_rdpipe #(.COL_W(COL_W)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .in_v(beat_v & beat_rd), .in_col(beat_col),
    .flush(wr_only), .cl(mode.cl), .out_v(rd_valid), .out_col(rd_col), .oe(dq_oe)
  );

  // read-side mask delay line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RD_MASK_LAT; i++) mdl[i] <= '0;
    end else begin
      mdl[0] <= dqm_in;
      for (int i = 1; i < RD_MASK_LAT; i++) mdl[i] <= mdl[i-1];
    end
  end

  assign wr_strobe = beat_v & ~beat_rd;

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign rd_byte_en[g] = rd_valid & ~mdl[RD_MASK_LAT-1][g];
    assign wr_byte_en[g] = wr_strobe & ~dqm_in[g];
  end

  always_comb begin
    if (rd_valid)       col_out = rd_col;
    else if (wr_strobe) col_out = beat_col;
    else                col_out = '0;
  end
endmodule

// File: rtl/sdram_burst_timer_chk.sv
module sdram_burst_timer_chk #(
  parameter int COL_W = 10,
  parameter int NBYTE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic [NBYTE-1:0] dqm_in,
  input logic             rd_valid,
  input logic             dq_oe,
  input logic [NBYTE-1:0] rd_byte_en,
  input logic             wr_strobe,
  input logic [COL_W-1:0] col_out,
  input logic             mode_err
);
  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  p_oe_covers_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> dq_oe);

  p_oe_preamble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(dq_oe));

  p_write_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rd) |-> wr_strobe);

  p_rd_mask_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_byte_en == ~$past(dqm_in, 2)));

  p_no_bus_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_strobe));

  p_read_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && cmd_wr) |-> !wr_strobe);

  p_col_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_strobe) |-> (col_out == '0));
endmodule

bind sdram_burst_timer sdram_burst_timer_chk #(.COL_W(COL_W), .NBYTE(NBYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .dqm_in(dqm_in),
  .rd_valid(rd_valid), .dq_oe(dq_oe), .rd_byte_en(rd_byte_en),
  .wr_strobe(wr_strobe), .col_out(col_out), .mode_err(mode_err)
);

// File: tb/test_sdram_burst_timer.sv
`timescale 1ns/1ps
module test_sdram_burst_timer;
  localparam int COL_W = 10;
  localparam int NB    = 4;
  localparam int N     = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_load = 1'b0;
  logic [9:0] mode_word = '0;
  logic cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_ap = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [NB-1:0] dqm_in = '0;
  logic rd_valid, dq_oe, wr_strobe, pre_start, mode_err;
  logic [NB-1:0] rd_byte_en, wr_byte_en;
  logic [COL_W-1:0] col_out;

  sdram_burst_timer #(.COL_W(COL_W), .NBYTE(NB)) i_sdram_burst_timer (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_ap(cmd_ap), .cmd_col(cmd_col),
    .dqm_in(dqm_in), .rd_valid(rd_valid), .dq_oe(dq_oe), .rd_byte_en(rd_byte_en),
    .wr_strobe(wr_strobe), .wr_byte_en(wr_byte_en), .col_out(col_out),
    .pre_start(pre_start), .mode_err(mode_err)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, t = 0;
  bit done = 0;
  string scen = "R1";

  bit e_rv[N]; int e_rc[N]; bit e_wv[N]; int e_wc[N]; bit e_pre[N]; int dqh[N];
  int m_bl = 1, m_cl = 2, m_intl = 0, m_single = 0;
  bit m_err = 0;

  task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (scenario %s) %s at cycle %0d: got=%0d exp=%0d", tag, scen, what, t, got, exp);
    end
  endtask

  function automatic int beat_col(input int s, input int k);
    int base;
    if (m_intl != 0) return s ^ k;
    base = s - (s % m_bl);
    return base + ((s % m_bl) + k) % m_bl;
  endfunction

  task automatic apply_mode(input int w);
    int lc, cc, wm;
    lc = w & 7; cc = (w >> 4) & 7; wm = (w >> 8) & 3;
    if (lc < 4 && (cc == 2 || cc == 3) && ((w >> 7) & 1) == 0 && (wm == 0 || wm == 2)) begin
      m_bl = 1 << lc; m_cl = cc; m_intl = (w >> 3) & 1; m_single = (wm == 2);
    end else begin
      m_bl = 1; m_cl = 2; m_intl = 0; m_single = 0; m_err = 1;
    end
  endtask

  task automatic step(input bit rd, input bit wr, input bit ap, input int col,
                      input bit ld = 0, input int word = 0);
    int len, erbe, ewbe, ecol;
    bit eoe;
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_ap = ap; cmd_col = COL_W'(col);
    mode_load = ld; mode_word = 10'(word);
    dqm_in = NB'((t * 5 + 3) % 16);
    dqh[t] = int'(dqm_in);
    if (rd) begin
      for (int s = t; s < N; s++) e_wv[s] = 0;
      for (int s = t + 1; s < N; s++) e_pre[s] = 0;
      for (int s = t + m_cl; s < N; s++) e_rv[s] = 0;
      for (int k = 0; k < m_bl; k++) begin
        e_rv[t + m_cl + k] = 1; e_rc[t + m_cl + k] = beat_col(col, k);
      end
      if (ap) e_pre[t + m_bl] = 1;
    end else if (wr) begin
      for (int s = t; s < N; s++) begin e_rv[s] = 0; e_wv[s] = 0; end
      for (int s = t + 1; s < N; s++) e_pre[s] = 0;
      len = m_single ? 1 : m_bl;
      for (int k = 0; k < len; k++) begin
        e_wv[t + k] = 1; e_wc[t + k] = beat_col(col, k);
      end
      if (ap) e_pre[t + len] = 1;
    end
    #1;
    eoe  = e_rv[t] | e_rv[t + 1];
    erbe = e_rv[t] ? (~dqh[t - 2] & 15) : 0;
    ewbe = e_wv[t] ? (~dqh[t] & 15) : 0;
    ecol = e_rv[t] ? e_rc[t] : (e_wv[t] ? e_wc[t] : 0);
    check(rd_valid == e_rv[t], "R3", "rd_valid", rd_valid, e_rv[t]);
    check(dq_oe == eoe, "R4", "dq_oe", dq_oe, eoe);
    check(wr_strobe == e_wv[t], "R5", "wr_strobe", wr_strobe, e_wv[t]);
    check(int'(col_out) == ecol, "R6", "col_out", col_out, ecol);
    check(int'(rd_byte_en) == erbe, "R7", "rd_byte_en", rd_byte_en, erbe);
    check(int'(wr_byte_en) == ewbe, "R7", "wr_byte_en", wr_byte_en, ewbe);
    check(pre_start == e_pre[t], "R8", "pre_start", pre_start, e_pre[t]);
    check(mode_err == m_err, "R2", "mode_err", mode_err, m_err);
    if (ld) apply_mode(word);
    t++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic load(input int w);
    step(0, 0, 0, 0, 1, w);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state, all outputs low
    check(!rd_valid && !dq_oe && !wr_strobe && !pre_start && !mode_err, "R1", "reset outputs",
          {rd_valid, dq_oe, wr_strobe, pre_start, mode_err}, 0);
    check(col_out == '0 && rd_byte_en == '0 && wr_byte_en == '0, "R1", "reset vectors",
          int'(col_out), 0);
    // R1: default mode is 1 beat, latency 2
    scen = "R1"; step(1, 0, 0, 37); idle(4);
    step(0, 1, 0, 12); idle(2);
    // R3/R6 BL4 sequential CL2
    load('h022); scen = "R3"; step(1, 0, 0, 5); idle(7);
    step(0, 1, 0, 6); idle(5);
    // R8 CL3 interleaved BL8 with auto-precharge
    load('h03B); scen = "R8"; step(1, 0, 1, 'h1A3); idle(12);
    load('h022); step(1, 0, 1, 9); idle(8);
    step(0, 1, 1, 6); idle(7);
    // R5 single-write mode
    load('h222); scen = "R5"; step(0, 1, 1, 14); idle(3);
    step(0, 1, 0, 3); idle(2); step(1, 0, 0, 2); idle(7);
    // R9 read during read, CL3 BL8
    load('h033); scen = "R9"; step(1, 0, 0, 16); idle(2); step(1, 0, 0, 40); idle(13);
    load('h023); step(1, 0, 1, 8); step(1, 0, 0, 100); idle(12);
    // R10 write during read
    scen = "R10"; step(1, 0, 0, 64); idle(2); step(0, 1, 0, 200); idle(10);
    step(1, 0, 0, 64); step(0, 1, 0, 7); idle(10);
    // R11 read during write
    scen = "R11"; step(0, 1, 1, 300); idle(2); step(1, 0, 0, 30); idle(12);
    // R12 both commands at once
    scen = "R12"; step(1, 1, 0, 77); idle(12);
    // R6 short bursts and wrap
    load('h029); scen = "R6"; step(1, 0, 0, 1023); idle(4); step(0, 1, 0, 510); idle(3);
    load('h031); step(1, 0, 1, 7); idle(6); step(0, 1, 0, 3); idle(3);
    load('h030); step(1, 0, 1, 99); idle(6);
    // R2 unsupported mode words and stickiness
    load('h0A2); scen = "R2"; step(1, 0, 1, 11); idle(5); step(0, 1, 0, 6); idle(3);
    load('h052); step(1, 0, 0, 4); idle(4);
    load('h022); step(1, 0, 0, 6); idle(7);
    load('h122); step(0, 1, 0, 9); idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL all watchdog expired at cycle %0d: got=running exp=finished", t);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule